// File: doc/BRIEF.md
# Byte-Stream Serial Register Front-End

This block is the software-visible side of a simple serial port. A 32-bit register bus reaches it through a small word-addressed window. On the other side sit two byte streams with valid/ready handshakes: one leaves towards a serial transmitter and one arrives from a serial receiver. A bus write to the transmit data register sends the low byte of the write data out as a single-cycle pulse on the outbound stream.

An inbound byte is caught in a one-entry holding register, and a receive-ready flag in the status register marks it. While that flag is set, the inbound ready output is low, so the receiver keeps a byte waiting instead of losing it. Reading the receive data register returns the held byte and empties the holder in the same access. The transmit-ready status bit is always 1, because the outbound stream takes every byte.

Bus reads return their data one cycle after the access. The status register ignores all writes, and offsets outside the three registers read as zero and discard writes. Baud timing, bit framing, FIFOs and interrupts are left to other blocks.

Top module: `ser_reg_bridge`

## Requirements
- R1: After reset, `rx_ready` is 1, `tx_valid` is 0, a status read returns 0x2 and a receive data read returns 0.
- R2: A valid write whose register index (`bus_addr[4:2]`) is 0 (byte offset 0x00, transmit data) makes `tx_valid` high for exactly the next cycle, with `tx_data` equal to `bus_wdata[7:0]`. No other access produces `tx_valid`.
- R3: `rx_ready` is the inverse of the receive-ready flag. A byte offered while `rx_ready` is 1 is stored, and `rx_ready` reads 0 from the next cycle.
- R4: While the holder is full, offered bytes are not taken, and the held byte and flag stay unchanged until the receive data register is read.
- R5: A valid read with index 1 (offset 0x04, receive data) returns the held byte in `bus_rdata[7:0]` on the next cycle, with the upper bits zero, and clears the receive-ready flag.
- R6: A valid read with index 5 (offset 0x14, status) returns bit 0 = receive-ready and bit 1 = transmit-ready (always 1) on the next cycle, with all other bits zero.
- R7: Writes to the status register change neither the flag, the held byte nor `tx_valid`.
- R8: Reads of the transmit data register and of unmapped indices (2, 3, 4, 6, 7) return zero. Writes to them, and writes to the receive data register, change no state. `bus_rdata` is zero in any cycle that does not follow a valid read.
- R9: An access is valid only when `bus_sel` is high and all four bits of `bus_be` are set. A partial access returns zero and has no side effect. The two low address bits do not affect decoding.
- R10: If a receive data read and an offered byte coincide while the holder is full, the read empties the holder and the byte is taken on the following cycle if it is still offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address within the window |
| bus_be | input | 4 | Byte enables; all four needed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| tx_valid | output | 1 | Outbound byte pulse |
| tx_data | output | 8 | Outbound byte |
| rx_valid | input | 1 | Inbound byte offered |
| rx_data | input | 8 | Inbound byte |
| rx_ready | output | 1 | Holder can take a byte |

## Verification
The assertions assume that the bus inputs are driven to known values from reset onward. They also assume that `rx_valid` and `rx_data` are sampled only at clock edges, with no requirement that an offered byte stays up while `rx_ready` is low. The stimulus changes every input once per cycle, away from the active edge. It drops and re-offers inbound bytes at random, which covers both a stream that keeps its byte waiting and one that withdraws it. Addresses cover the whole 5-bit space with random low bits, and byte enables are sometimes partial, so decoding is exercised beyond the three mapped registers.

// File: rtl/ser_reg_pkg.sv
// Shared constants and types for the serial register front-end.
// Assumes a word-addressed window where index = byte address >> 2.
package ser_reg_pkg;

    parameter int BUS_W  = 32;
    parameter int BYTE_W = 8;
    parameter int BE_W   = BUS_W / 8;

    // Register indices; the values matter because software uses them.
    parameter int IDX_TXD  = 0;
    parameter int IDX_RXD  = 1;
    parameter int IDX_STAT = 5;
    parameter int IDX_LAST = 5;   // highest index inside the 0x18 window

    // Status bit positions.
    parameter int STAT_RX_BIT = 0;
    parameter int STAT_TX_BIT = 1;

    // Decoded bus access, one strobe per effect.
    typedef struct packed {
        logic tx_wr;     // write to transmit data
        logic rx_rd;     // read of receive data
        logic st_rd;     // read of status
        logic other_rd;  // valid read returning zero
    } access_t;

endpackage

// File: rtl/ser_reg_decode.sv
// Address decoder: turns one bus cycle into effect strobes.
// Assumes only full-word accesses are legal; the rest are dropped silently.
module ser_reg_decode
    import ser_reg_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    output access_t           acc
);
    localparam int IDX_W = ADDR_W - 2;

    logic             valid;
    logic [IDX_W-1:0] idx;

    // Decode legality and register index, then raise one strobe.
    always_comb begin
        valid        = sel && (be == {BE_W{1'b1}});
        idx          = addr[ADDR_W-1:2];
        acc          = '0;
        acc.tx_wr    = valid &&  wr && (idx == IDX_W'(IDX_TXD));
        acc.rx_rd    = valid && !wr && (idx == IDX_W'(IDX_RXD));
        acc.st_rd    = valid && !wr && (idx == IDX_W'(IDX_STAT));
        acc.other_rd = valid && !wr && !acc.rx_rd && !acc.st_rd;
    end
endmodule

// File: rtl/ser_rx_holder.sv
// One-entry receive holder with a full flag.
// Assumes the read-clear strobe comes from a decoded bus read; while full,
// the ready output is low, so an offered byte is left waiting, not dropped.
module ser_rx_holder #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    input  logic              rd_clr,
    output logic [BYTE_W-1:0] held,
    output logic              full
);
    logic take;

    // Handshake: accept only while empty.
    always_comb begin
        in_ready = !full;
        take     = in_valid && in_ready;
    end

    // Flag: a take sets it, a read clears it, a take wins on overlap.
    always_ff @(posedge clk) begin
        if (!rst_n)      full <= 1'b0;
        else if (take)   full <= 1'b1;
        else if (rd_clr) full <= 1'b0;
    end

    // Data: capture the byte on a take.
    always_ff @(posedge clk) begin
        if (!rst_n)    held <= '0;
        else if (take) held <= in_data;
    end
endmodule

// File: rtl/ser_tx_pulse.sv
// Outbound byte emitter: one valid pulse the cycle after a data write.
// Assumes the downstream serial core always takes the byte.
module ser_tx_pulse #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wbyte,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data
);
    // Pulse register: valid follows the write strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= wr;
    end

    // Data register: load the byte only on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)  out_data <= '0;
        else if (wr) out_data <= wbyte;
    end
endmodule

// File: rtl/ser_reg_bridge.sv
// Top: register window (tx data, rx data, status) over byte streams.
// Assumes a bus that samples read data one cycle after the request.
// The status register is read-only; writes to it are discarded.
module ser_reg_bridge
    import ser_reg_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready
);
    access_t           acc;
    logic [BYTE_W-1:0] held;
    logic              full;
    logic [BUS_W-1:0]  rd_next;

    ser_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel  (bus_sel),
        .wr   (bus_wr),
        .addr (bus_addr),
        .be   (bus_be),
        .acc  (acc)
    );

    ser_rx_holder #(.BYTE_W(BYTE_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (rx_valid),
        .in_data  (rx_data),
        .in_ready (rx_ready),
        .rd_clr   (acc.rx_rd),
        .held     (held),
        .full     (full)
    );

    ser_tx_pulse #(.BYTE_W(BYTE_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (acc.tx_wr),
        .wbyte     (bus_wdata[BYTE_W-1:0]),
        .out_valid (tx_valid),
        .out_data  (tx_data)
    );

    // Read mux: select the addressed register, zero otherwise.
    always_comb begin
        rd_next = '0;
        if (acc.rx_rd) begin
            rd_next[BYTE_W-1:0] = held;
        end else if (acc.st_rd) begin
            rd_next[STAT_RX_BIT] = full;
            rd_next[STAT_TX_BIT] = 1'b1;
        end
    end

    // Read data register: present the selected value one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_next;
    end
endmodule

// File: rtl/ser_reg_bridge_chk.sv
// Port-level checker for ser_reg_bridge, bound to every instance.
module ser_reg_bridge_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_be,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              rx_valid,
    input logic              rx_ready
);
    localparam int IDX_W = ADDR_W - 2;

    logic             ok;
    logic [IDX_W-1:0] ix;
    logic             txw, rxr, str, zrd;

    always_comb begin
        ok  = bus_sel && (bus_be == 4'hF);
        ix  = bus_addr[ADDR_W-1:2];
        txw = ok &&  bus_wr && (ix == IDX_W'(0));
        rxr = ok && !bus_wr && (ix == IDX_W'(1));
        str = ok && !bus_wr && (ix == IDX_W'(5));
        zrd = ok && !bus_wr && !rxr && !str;
    end

    a_r2_tx_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        txw |=> (tx_valid && tx_data == $past(bus_wdata[7:0])));

    a_r2_tx_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !txw |=> !tx_valid);

    a_r3_take_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |=> !rx_ready);

    a_r4_full_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready && !rxr) |=> !rx_ready);

    a_r5_read_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready && rxr) |=> rx_ready);

    a_r5_rx_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rxr |=> (bus_rdata[31:8] == 24'd0));

    a_r6_status_shape: assert property (@(posedge clk) disable iff (!rst_n)
        str |=> (bus_rdata[31:2] == 30'd0 && bus_rdata[1] &&
                 bus_rdata[0] == !$past(rx_ready)));

    a_r8_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (zrd || !(ok && !bus_wr)) |=> (bus_rdata == 32'd0));

    a_r9_partial_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_be != 4'hF) |=> (!tx_valid && bus_rdata == 32'd0));
endmodule

bind ser_reg_bridge ser_reg_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready)
);

// File: tb/ser_reg_bridge_bench.sv
// Self-checking bench: directed corners, then seeded random traffic.
module ser_reg_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;

    int checks = 0;
    int errors = 0;
    bit m_full = 1'b0;
    logic [7:0] m_hold = 8'h00;

    always #2 clk = ~clk;   // 250 MHz

    ser_reg_bridge u_ser_reg_bridge (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(bit sel, bit wr, logic [4:0] a, logic [3:0] be);
        logic [31:0] v = '0;
        if (sel && be == 4'hF && !wr) begin
            if (a[4:2] == 3'd1) v = {24'd0, m_hold};
            else if (a[4:2] == 3'd5) v = {30'd0, 1'b1, m_full};
        end
        return v;
    endfunction

    function automatic bit exp_tx(bit sel, bit wr, logic [4:0] a, logic [3:0] be);
        return sel && wr && be == 4'hF && a[4:2] == 3'd0;
    endfunction

    // One bus cycle: drive at negedge, update the model, check at next negedge.
    task automatic step(string tag, bit sel, bit wr, logic [4:0] a, logic [3:0] be,
                        logic [31:0] wd, bit rv, logic [7:0] rd);
        logic [31:0] e_rd;
        bit e_tx, take, clr;
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = wd;
        rx_valid = rv; rx_data = rd;
        e_rd = exp_rd(sel, wr, a, be);
        e_tx = exp_tx(sel, wr, a, be);
        take = rv && !m_full;
        clr  = sel && !wr && be == 4'hF && a[4:2] == 3'd1;
        if (take) begin m_full = 1'b1; m_hold = rd; end
        else if (clr) m_full = 1'b0;
        @(negedge clk);
        check(tag, "bus_rdata", bus_rdata, e_rd);
        check(tag, "tx_valid", {31'd0, tx_valid}, {31'd0, e_tx});
        if (e_tx) check(tag, "tx_data", {24'd0, tx_data}, {24'd0, wd[7:0]});
        check(tag, "rx_ready", {31'd0, rx_ready}, {31'd0, !m_full});
    endtask

    task automatic idle(string tag);
        step(tag, 1'b0, 1'b0, 5'd0, 4'h0, 32'd0, 1'b0, 8'd0);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", "rx_ready after reset", {31'd0, rx_ready}, 32'd1);
        check("R1", "tx_valid after reset", {31'd0, tx_valid}, 32'd0);
        step("R1", 1, 0, 5'h14, 4'hF, 0, 0, 0);            // status reads 0x2
        step("R1", 1, 0, 5'h04, 4'hF, 0, 0, 0);            // rx data reads 0
        step("R2", 1, 1, 5'h00, 4'hF, 32'hABCD_125A, 0, 0);
        step("R2", 1, 1, 5'h03, 4'hF, 32'h0000_00C3, 0, 0); // low bits ignored
        idle("R2");                                          // pulse lasts one cycle
        step("R3", 0, 0, 0, 0, 0, 1, 8'h7E);                // accept
        step("R6", 1, 0, 5'h14, 4'hF, 0, 1, 8'h11);         // status while full
        step("R4", 0, 0, 0, 0, 0, 1, 8'h22);                // held off
        step("R7", 1, 1, 5'h14, 4'hF, 32'hFFFF_FFFF, 0, 0); // status write
        step("R8", 1, 1, 5'h04, 4'hF, 32'h55, 0, 0);        // rx data write dropped
        step("R8", 1, 1, 5'h0C, 4'hF, 32'h66, 0, 0);        // unmapped write
        step("R8", 1, 0, 5'h00, 4'hF, 0, 0, 0);             // tx data reads 0
        step("R8", 1, 0, 5'h18, 4'hF, 0, 0, 0);             // beyond window
        step("R9", 1, 0, 5'h04, 4'h7, 0, 0, 0);             // partial read
        step("R9", 1, 1, 5'h00, 4'hE, 32'h99, 0, 0);        // partial write
        step("R5", 1, 0, 5'h14, 4'hF, 0, 0, 0);             // still full
        step("R10", 1, 0, 5'h04, 4'hF, 0, 1, 8'h3C);        // read + offer
        step("R10", 0, 0, 0, 0, 0, 1, 8'h3C);               // taken now
        step("R10", 1, 0, 5'h04, 4'hF, 0, 0, 0);            // returns 0x3C
        idle("R5");
        for (int i = 0; i < 3000; i++) begin
            bit s, w, rv;
            logic [3:0] be;
            s  = ($urandom % 4) != 0;
            w  = $urandom % 2;
            be = (($urandom % 8) == 0) ? 4'($urandom) : 4'hF;
            rv = ($urandom % 3) != 0;
            step("R5", s, w, 5'($urandom), be, $urandom, rv, 8'($urandom));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule